// File: doc/BRIEF.md
# Scrunching Event Priority Queue

This block is the on-chip, time-ordered event store of a discrete-event simulation pipeline. It keeps a register array of pending events, each carrying a 32-bit timestamp and two 12-bit particle tags, in timestamp order. In every cycle the consumer can take the earliest event, up to four producers can each insert one new event, and a single broadcast tag can cancel every stored event that refers to that particle.

Cancellation leaves empty slots ("holes") scattered through the array. The block does not re-sort to remove them. Each stored event instead slides toward the head by at most two slots per cycle, depending on how many empty slots lie ahead of it, so the array compacts over a few cycles. The head output always shows the first occupied slot, so dequeue stays correct while holes are still present. An insertion for which there is no free slot at the tail is refused and flagged in the same cycle.

Top module: `event_pq`

## Requirements
- R1: After reset the queue is empty: `head_valid` is 0 and `stall` is 0.
- R2: When `head_valid` is 1, `head_time`, `head_tag_a` and `head_tag_b` belong to the stored event with the smallest timestamp. Timestamps compare as unsigned numbers.
- R3: A cycle with `pop` high and `head_valid` high removes the displayed head event. `pop` while the queue is empty has no effect.
- R4: Any subset of the four insertion ports may be valid in one cycle, with timestamps in any order. Port k takes its timestamp from `ins_time[32k+31:32k]` and its tags from bits `[12k+11:12k]` of `ins_tag_a` and `ins_tag_b`. Every accepted event is dequeued in timestamp order.
- R5: Events with equal timestamps leave in arrival order: an event already stored goes before a new one, and among events inserted in the same cycle the lower port number goes first.
- R6: With `inv_en` high, every stored event whose `tag_a` or `tag_b` equals `inv_tag` is removed in that cycle, however many events match.
- R7: In the cycle after a cancellation, the head output skips the emptied slots and shows the earliest surviving event.
- R8: Slots emptied by cancellation are reclaimed within a few idle cycles. Once the holes have closed, the queue again accepts events up to the full capacity `DEPTH` (32 by default).
- R9: In a cycle where fewer free tail slots exist than valid insertion ports, ports are accepted in ascending port order until the free slots run out. The remaining ports are dropped and `stall` is high in that same cycle. When every valid port is accepted, `stall` is 0.
- R10: When a pop and an insertion occur in the same cycle, the removed event is the head shown before that clock edge, and the new event is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pop | input | 1 | Remove the displayed head event at this edge |
| ins_valid | input | NPORT | One insertion request per port |
| ins_time | input | NPORT*32 | Timestamps of the insertion ports, port 0 in the low bits |
| ins_tag_a | input | NPORT*12 | First particle tag of each insertion port |
| ins_tag_b | input | NPORT*12 | Second particle tag of each insertion port |
| inv_en | input | 1 | Cancel all events that carry `inv_tag` |
| inv_tag | input | 12 | Particle tag broadcast for cancellation |
| head_valid | output | 1 | Queue holds at least one event |
| head_time | output | 32 | Timestamp of the earliest event |
| head_tag_a | output | 12 | First tag of the earliest event |
| head_tag_b | output | 12 | Second tag of the earliest event |
| stall | output | 1 | At least one valid insertion is refused this cycle |

## Verification
The hardest condition to create from the ports is a full array with holes in its middle. Holes cannot be seen directly, and compaction only becomes visible through the tail capacity it frees. To reach this state, the stimulus fills all 32 slots and then cancels one tag carried by six events spread across the array. It then idles for a few cycles and inserts six more events. If those six are accepted without `stall` and the drain returns exactly 32 events in order, the holes were closed rather than left in place. A second case fills 30 slots and then offers four events at once, which exercises the partial-acceptance order of the overflow rule.

// File: rtl/epq_pkg.sv
package epq_pkg;
  localparam int TS_W  = 32;
  localparam int TAG_W = 12;

  typedef struct packed {
    logic             vld;
    logic [TS_W-1:0]  ts;
    logic [TAG_W-1:0] tag_a;
    logic [TAG_W-1:0] tag_b;
  } epq_ent_t;
endpackage

// File: rtl/epq_head.sv
// Finds the lowest occupied slot; holes are skipped.
module epq_head
  import epq_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int IW    = $clog2(DEPTH)
) (
  input  epq_ent_t         slots [DEPTH],
  output logic             found,
  output logic [IW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (slots[i].vld) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/epq_compact.sv
// Applies tag cancellation and head removal, then gives every survivor
// its advanced position: it moves toward the head by the number of empty
// slots in front of it, saturated at two.
module epq_compact
  import epq_pkg::*;
#(
  parameter  int DEPTH = 32,
  parameter  int PW    = 7,
  localparam int IW    = $clog2(DEPTH)
) (
  input  epq_ent_t          slots [DEPTH],
  input  logic              pop_hit,
  input  logic [IW-1:0]     pop_idx,
  input  logic              inv_en,
  input  logic [TAG_W-1:0]  inv_tag,
  output logic [DEPTH-1:0]  keep,
  output logic [PW-1:0]     cpos [DEPTH],
  output logic [PW-1:0]     tail_end
);
  always_comb begin
    logic [1:0] gap;
    logic       kill;
    gap      = 2'd0;
    tail_end = '0;
    for (int j = 0; j < DEPTH; j++) begin
      kill = (inv_en && (slots[j].tag_a == inv_tag || slots[j].tag_b == inv_tag))
          || (pop_hit && pop_idx == IW'(j));
      keep[j] = slots[j].vld && !kill;
      cpos[j] = PW'(j) - PW'(gap);
      if (keep[j]) tail_end = cpos[j] + 1'b1;
      else if (gap != 2'd2) gap = gap + 2'd1;
    end
  end
endmodule

// File: rtl/epq_insert.sv
// Accepts new events against the free tail, ranks them among themselves
// and against survivors, and returns destinations and survivor shifts.
module epq_insert
  import epq_pkg::*;
#(
  parameter  int DEPTH = 32,
  parameter  int NPORT = 4,
  parameter  int PW    = 7,
  localparam int CW    = $clog2(NPORT + 1)
) (
  input  epq_ent_t          slots  [DEPTH],
  input  logic [DEPTH-1:0]  keep,
  input  logic [PW-1:0]     cpos   [DEPTH],
  input  logic [PW-1:0]     tail_end,
  input  logic [NPORT-1:0]  req,
  input  logic [TS_W-1:0]   req_ts [NPORT],
  output logic [NPORT-1:0]  acc,
  output logic [PW-1:0]     dest   [NPORT],
  output logic [CW-1:0]     rshift [DEPTH]
);
  logic [PW-1:0] room;
  assign room = PW'(DEPTH) - tail_end;

  // lower ports claim free tail slots first
  always_comb begin
    logic [PW-1:0] taken;
    taken = '0;
    for (int k = 0; k < NPORT; k++) begin
      acc[k] = req[k] && (taken < room);
      if (acc[k]) taken = taken + 1'b1;
    end
  end

  // new event k lands right after its last survivor with ts <= its own,
  // offset by the accepted new events ordered before it
  always_comb begin
    logic [CW-1:0] nb;
    logic [PW-1:0] base;
    for (int k = 0; k < NPORT; k++) begin
      nb = '0;
      for (int m = 0; m < NPORT; m++) begin
        if (m != k && acc[m] &&
            (req_ts[m] < req_ts[k] || (req_ts[m] == req_ts[k] && m < k)))
          nb = nb + 1'b1;
      end
      base = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (keep[j] && slots[j].ts <= req_ts[k]) base = cpos[j] + 1'b1;
      end
      dest[k] = base + PW'(nb);
    end
  end

  // a survivor moves back by the count of new events strictly earlier
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      rshift[j] = '0;
      for (int k = 0; k < NPORT; k++) begin
        if (acc[k] && req_ts[k] < slots[j].ts) rshift[j] = rshift[j] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/event_pq.sv
module event_pq
  import epq_pkg::*;
#(
  parameter  int DEPTH = 32,
  parameter  int NPORT = 4,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = $clog2(DEPTH + 1) + 1,
  localparam int CW    = $clog2(NPORT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pop,
  input  logic [NPORT-1:0]       ins_valid,
  input  logic [NPORT*TS_W-1:0]  ins_time,
  input  logic [NPORT*TAG_W-1:0] ins_tag_a,
  input  logic [NPORT*TAG_W-1:0] ins_tag_b,
  input  logic                   inv_en,
  input  logic [TAG_W-1:0]       inv_tag,
  output logic                   head_valid,
  output logic [TS_W-1:0]        head_time,
  output logic [TAG_W-1:0]       head_tag_a,
  output logic [TAG_W-1:0]       head_tag_b,
  output logic                   stall
);
  epq_ent_t          slots_q [DEPTH];
  epq_ent_t          nxt     [DEPTH];
  epq_ent_t          new_ent [NPORT];
  logic [TS_W-1:0]   new_ts  [NPORT];
  logic              hfound;
  logic [IW-1:0]     hidx;
  logic [DEPTH-1:0]  keep;
  logic [PW-1:0]     cpos    [DEPTH];
  logic [PW-1:0]     tail_end;
  logic [NPORT-1:0]  acc;
  logic [PW-1:0]     dest    [NPORT];
  logic [CW-1:0]     rshift  [DEPTH];

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    assign new_ts[k]  = ins_time[k*TS_W +: TS_W];
    assign new_ent[k] = '{vld:   1'b1,
                          ts:    ins_time[k*TS_W +: TS_W],
                          tag_a: ins_tag_a[k*TAG_W +: TAG_W],
                          tag_b: ins_tag_b[k*TAG_W +: TAG_W]};
  end

  epq_head #(.DEPTH(DEPTH)) u_head (
    .slots (slots_q),
    .found (hfound),
    .idx   (hidx)
  );

  epq_compact #(.DEPTH(DEPTH), .PW(PW)) u_compact (
    .slots    (slots_q),
    .pop_hit  (pop && hfound),
    .pop_idx  (hidx),
    .inv_en   (inv_en),
    .inv_tag  (inv_tag),
    .keep     (keep),
    .cpos     (cpos),
    .tail_end (tail_end)
  );

  epq_insert #(.DEPTH(DEPTH), .NPORT(NPORT), .PW(PW)) u_insert (
    .slots    (slots_q),
    .keep     (keep),
    .cpos     (cpos),
    .tail_end (tail_end),
    .req      (ins_valid),
    .req_ts   (new_ts),
    .acc      (acc),
    .dest     (dest),
    .rshift   (rshift)
  );

  // each slot picks the single survivor or new event routed to it
  always_comb begin
    for (int d = 0; d < DEPTH; d++) begin
      nxt[d] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (keep[j] && (cpos[j] + PW'(rshift[j])) == PW'(d)) nxt[d] = slots_q[j];
      end
      for (int k = 0; k < NPORT; k++) begin
        if (acc[k] && dest[k] == PW'(d)) nxt[d] = new_ent[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) slots_q[i] <= '0;
      else     slots_q[i] <= nxt[i];
    end
  end

  assign head_valid = hfound;
  assign head_time  = slots_q[hidx].ts;
  assign head_tag_a = slots_q[hidx].tag_a;
  assign head_tag_b = slots_q[hidx].tag_b;
  assign stall      = |(ins_valid & ~acc);
endmodule

// File: rtl/epq_checker.sv
module epq_checker
  import epq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NPORT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NPORT-1:0]  ins_valid,
  input logic              inv_en,
  input logic [TAG_W-1:0]  inv_tag,
  input logic              head_valid,
  input logic [TS_W-1:0]   head_time,
  input logic [TAG_W-1:0]  head_tag_a,
  input logic [TAG_W-1:0]  head_tag_b,
  input logic              stall,
  input epq_ent_t          slots_q [DEPTH]
);
  p_reset_empty_r1: assert property (@(posedge clk) rst |=> !head_valid);

  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_order
    p_slot_order_r2: assert property (@(posedge clk) disable iff (rst)
      (slots_q[i].vld && slots_q[i+1].vld) |-> slots_q[i].ts <= slots_q[i+1].ts);
  end

  p_head_no_regress_r3: assert property (@(posedge clk) disable iff (rst)
    (head_valid && ins_valid == '0) |=> (!head_valid || head_time >= $past(head_time)));

  p_empty_stays_r3: assert property (@(posedge clk) disable iff (rst)
    (!head_valid && ins_valid == '0) |=> !head_valid);

  p_cancel_gone_r6: assert property (@(posedge clk) disable iff (rst)
    (inv_en && ins_valid == '0) |=>
      (!head_valid || (head_tag_a != $past(inv_tag) && head_tag_b != $past(inv_tag))));

  p_stall_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ins_valid != '0));

  p_empty_no_stall_r9: assert property (@(posedge clk) disable iff (rst)
    !head_valid |-> !stall);
endmodule

bind event_pq epq_checker #(.DEPTH(DEPTH), .NPORT(NPORT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ins_valid  (ins_valid),
  .inv_en     (inv_en),
  .inv_tag    (inv_tag),
  .head_valid (head_valid),
  .head_time  (head_time),
  .head_tag_a (head_tag_a),
  .head_tag_b (head_tag_b),
  .stall      (stall),
  .slots_q    (slots_q)
);

// File: tb/event_pq_test.sv
module event_pq_test;
  import epq_pkg::*;
  localparam int NP = 4;

  logic                clk = 1'b0;
  logic                rst;
  logic                pop;
  logic [NP-1:0]       ins_valid;
  logic [NP*TS_W-1:0]  ins_time;
  logic [NP*TAG_W-1:0] ins_tag_a;
  logic [NP*TAG_W-1:0] ins_tag_b;
  logic                inv_en;
  logic [TAG_W-1:0]    inv_tag;
  logic                head_valid;
  logic [TS_W-1:0]     head_time;
  logic [TAG_W-1:0]    head_tag_a;
  logic [TAG_W-1:0]    head_tag_b;
  logic                stall;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_t [0:63];
  int exp_a [0:63];

  always #4 clk = ~clk;

  event_pq #(.DEPTH(32), .NPORT(NP)) uut (
    .clk(clk), .rst(rst), .pop(pop), .ins_valid(ins_valid), .ins_time(ins_time),
    .ins_tag_a(ins_tag_a), .ins_tag_b(ins_tag_b), .inv_en(inv_en), .inv_tag(inv_tag),
    .head_valid(head_valid), .head_time(head_time), .head_tag_a(head_tag_a),
    .head_tag_b(head_tag_b), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic quiet();
    ins_valid = '0;
    pop       = 1'b0;
    inv_en    = 1'b0;
  endtask

  task automatic put(input int k, input int t, input int a, input int b);
    ins_valid[k]                 = 1'b1;
    ins_time[k*TS_W +: TS_W]     = TS_W'(t);
    ins_tag_a[k*TAG_W +: TAG_W]  = TAG_W'(a);
    ins_tag_b[k*TAG_W +: TAG_W]  = TAG_W'(b);
  endtask

  // pop n events, comparing each head with exp_t/exp_a, then expect empty
  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(head_valid == 1'b1, req, "head_valid during drain", head_valid, 1);
      check(head_time == TS_W'(exp_t[i]), req, "head_time", head_time, exp_t[i]);
      check(head_tag_a == TAG_W'(exp_a[i]), req, "head_tag_a", head_tag_a, exp_a[i]);
      pop = 1'b1;
      step();
    end
    pop = 1'b0;
    check(head_valid == 1'b0, "R3", "empty after drain", head_valid, 0);
  endtask

  // n events, four per cycle: ts = t0 + i*dt, tag_a = i,
  // tag_b = 'h55 on every i%5==2 when mark is set, else i+256
  task automatic fill_seq(input int n, input int t0, input int dt, input bit mark);
    for (int i = 0; i < n; i += 4) begin
      for (int k = 0; k < 4; k++) begin
        if (i + k < n)
          put(k, t0 + (i + k) * dt, i + k, (mark && (i + k) % 5 == 2) ? 'h55 : (i + k + 256));
      end
      check(stall == 1'b0, "R9", "no stall while filling", stall, 0);
      step();
      ins_valid = '0;
    end
  endtask

  task automatic t_reset_r1();
    rst = 1'b1;
    quiet();
    ins_time = '0; ins_tag_a = '0; ins_tag_b = '0; inv_tag = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    check(head_valid == 1'b0, "R1", "head_valid after reset", head_valid, 0);
    check(stall == 1'b0, "R1", "stall after reset", stall, 0);
  endtask

  task automatic t_multi_insert_r4();
    put(0, 40, 4, 0); put(1, 10, 1, 0); put(2, 30, 3, 0); put(3, 20, 2, 0);
    step();
    quiet();
    check(head_time == 10, "R2", "earliest shown at head", head_time, 10);
    exp_t[0] = 10; exp_a[0] = 1; exp_t[1] = 20; exp_a[1] = 2;
    exp_t[2] = 30; exp_a[2] = 3; exp_t[3] = 40; exp_a[3] = 4;
    drain(4, "R4");
  endtask

  task automatic t_pop_empty_r3();
    pop = 1'b1;
    step(); step();
    check(head_valid == 1'b0, "R3", "pop on empty stays empty", head_valid, 0);
    put(0, 7, 77, 0);
    step();
    quiet();
    check(head_valid == 1'b1, "R3", "event kept despite pop on empty", head_valid, 1);
    check(head_time == 7, "R3", "event time after pop on empty", head_time, 7);
    exp_t[0] = 7; exp_a[0] = 77;
    drain(1, "R3");
  endtask

  task automatic t_equal_times_r5();
    put(0, 50, 9, 0);
    step();
    quiet();
    put(0, 60, 20, 0); put(1, 50, 11, 0); put(3, 50, 13, 0);
    step();
    quiet();
    exp_t[0] = 50; exp_a[0] = 9;  exp_t[1] = 50; exp_a[1] = 11;
    exp_t[2] = 50; exp_a[2] = 13; exp_t[3] = 60; exp_a[3] = 20;
    drain(4, "R5");
  endtask

  task automatic t_cancel_r6_r7();
    put(0, 100, 5, 'h77); put(1, 110, 6, 0); put(2, 120, 'h77, 7); put(3, 130, 8, 9);
    step();
    quiet();
    put(0, 140, 10, 'h77); put(1, 150, 11, 12); put(2, 160, 13, 14); put(3, 170, 15, 16);
    step();
    quiet();
    check(head_time == 100, "R6", "head before cancel", head_time, 100);
    inv_en = 1'b1; inv_tag = 'h77;
    step();
    quiet();
    check(head_valid == 1'b1, "R7", "survivor shown after cancel", head_valid, 1);
    check(head_time == 110, "R7", "hole skipped at head", head_time, 110);
    exp_t[0] = 110; exp_a[0] = 6;  exp_t[1] = 130; exp_a[1] = 8;
    exp_t[2] = 150; exp_a[2] = 11; exp_t[3] = 160; exp_a[3] = 13;
    exp_t[4] = 170; exp_a[4] = 15;
    drain(5, "R6");
  endtask

  task automatic t_pop_and_insert_r10();
    put(0, 10, 1, 0); put(1, 20, 2, 0);
    step();
    quiet();
    pop = 1'b1;
    put(0, 5, 3, 0);
    step();
    quiet();
    check(head_time == 5, "R10", "new event at head after pop+insert", head_time, 5);
    exp_t[0] = 5; exp_a[0] = 3; exp_t[1] = 20; exp_a[1] = 2;
    drain(2, "R10");
  endtask

  task automatic t_overflow_r9();
    fill_seq(30, 1000, 10, 1'b0);
    put(0, 5, 100, 0); put(1, 6, 101, 0); put(2, 7, 102, 0); put(3, 8, 103, 0);
    #1;
    check(stall == 1'b1, "R9", "stall with two free slots and four requests", stall, 1);
    step();
    quiet();
    put(0, 9000, 200, 0); put(1, 9001, 201, 0);
    #1;
    check(stall == 1'b1, "R9", "stall when full", stall, 1);
    step();
    quiet();
    exp_t[0] = 5; exp_a[0] = 100; exp_t[1] = 6; exp_a[1] = 101;
    for (int i = 0; i < 30; i++) begin
      exp_t[i+2] = 1000 + i * 10;
      exp_a[i+2] = i;
    end
    drain(32, "R9");
  endtask

  task automatic t_compaction_r8();
    int n;
    fill_seq(32, 2000, 10, 1'b1);
    inv_en = 1'b1; inv_tag = 'h55;
    step();
    quiet();
    repeat (8) step();
    put(0, 1, 200, 0); put(1, 2, 201, 0); put(2, 3, 202, 0); put(3, 4, 203, 0);
    #1;
    check(stall == 1'b0, "R8", "reclaimed slots accept four", stall, 0);
    step();
    quiet();
    put(0, 9998, 204, 0); put(1, 9999, 205, 0);
    #1;
    check(stall == 1'b0, "R8", "reclaimed slots accept last two", stall, 0);
    step();
    quiet();
    for (int i = 0; i < 4; i++) begin
      exp_t[i] = i + 1;
      exp_a[i] = 200 + i;
    end
    n = 4;
    for (int i = 0; i < 32; i++) begin
      if (i % 5 != 2) begin
        exp_t[n] = 2000 + i * 10;
        exp_a[n] = i;
        n++;
      end
    end
    exp_t[n] = 9998; exp_a[n] = 204; n++;
    exp_t[n] = 9999; exp_a[n] = 205; n++;
    drain(n, "R8");
  endtask

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_multi_insert_r4();
    t_pop_empty_r3();
    t_equal_times_r5();
    t_cancel_r6_r7();
    t_pop_and_insert_r10();
    t_overflow_r9();
    t_compaction_r8();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule